// File: doc/BRIEF.md
# Timer Pin Controller: GPIO Drive and Edge Capture

This block controls the one external pin of a timer channel. A role field in a control word picks what the pin is for. In the GPIO role the pin either floats as an input or is driven low or high, and an open-drain option releases the pin instead of driving it high. In the capture role the block watches the pin for a programmed kind of edge and latches sticky event flags. A mask bit passes the event flag to an interrupt line.

The pin is first passed through a two-flop synchroniser. Its synchronised level can be read in every role. Edges are found by comparing that level with the previous synchronised sample. Software clears flags by writing ones to them. If an edge and a clearing write land in the same cycle, the new flag survives. If edge detection is armed while the pin is in the GPIO role, the pin is held as an input whatever output state is requested. The counting timer and waveform generation are outside this block.

Top module: `tpin_ctl`

## Requirements
- R1: After reset `mode_q`, `status_q`, `pin_oe`, `pin_out` and `irq` are all zero. A write on `mode_we` is visible on `mode_q` after the next clock edge.
- R2: In role 4 (GPIO, `mode_q[2:0]`), the state field `mode_q[5:4]` gives the pin state: 00 or 01 leaves the pin undriven (`pin_oe`=0), 10 drives low (`pin_oe`=1, `pin_out`=0), and 11 drives high (`pin_oe`=1, `pin_out`=1). `pin_out` is 0 whenever `pin_oe` is 0.
- R3: With the open-drain bit `mode_q[9]` set, state 11 releases the pin (`pin_oe`=0). State 10 still drives low.
- R4: In every role other than 4 (0 off, 1 capture, 2 compare, 3 PWM, 5 to 7 unused), `pin_oe` is 0.
- R5: `status_q[8]` shows `pin_in` delayed by two clock edges, in every role.
- R6: The edge select `mode_q[17:16]` means 01 rising, 10 falling, 11 either, 00 none. A matching edge on `pin_in` that is set up before clock edge k sets event flag `status_q[0]` after edge k+2.
- R7: A captured rising edge also sets `status_q[1]`. A captured falling edge also sets `status_q[2]`.
- R8: A captured edge that arrives while `status_q[0]` is already set also sets the overrun flag `status_q[3]`.
- R9: A one in `clr_bits` with `clr_we` clears that flag bit and leaves flags whose bit is zero unchanged. A flag that an edge sets in the same cycle stays set.
- R10: `irq` is high exactly when interrupt enable `mode_q[8]` and `status_q[0]` are both 1.
- R11: Edge detection is armed in role 1, and in role 4 when the edge select is non-zero. In the latter case `pin_oe` stays 0 whatever `mode_q[5:4]` says. Edges are never captured in other roles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the control word |
| mode_wdata | input | MODE_W | Control word to write |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | FLAG_W | Flag bits to clear (ones clear) |
| pin_in | input | 1 | Asynchronous pin level |
| pin_oe | output | 1 | Pin output enable |
| pin_out | output | 1 | Pin output value |
| mode_q | output | MODE_W | Current control word |
| status_q | output | STAT_W | Flags in [FLAG_W-1:0], pin level in bit 8 |
| irq | output | 1 | Edge interrupt request |

## Verification
The bench uses the default widths (32-bit control and status words, four flags) and a two-stage synchroniser. With these values, the edge-to-flag latency of R6 is three edges and every field position in the requirements is in range. Directed steps cover each pin state, the open-drain release, each edge select, overrun stacking, and a clear that lands together with an edge. A random phase then mixes roles, edge selects and clears against the reference model. This exercises role changes while pin samples are still in the synchroniser.

// File: rtl/tpin_pkg.sv
package tpin_pkg;

  typedef enum logic [2:0] {
    ROLE_OFF  = 3'd0,
    ROLE_CAPT = 3'd1,
    ROLE_CMP  = 3'd2,
    ROLE_PWM  = 3'd3,
    ROLE_GPIO = 3'd4
  } role_e;

  // control word field positions
  localparam int ROLE_LSB = 0;
  localparam int ROLE_W   = 3;
  localparam int DIR_LSB  = 4;
  localparam int IEN_BIT  = 8;
  localparam int OD_BIT   = 9;
  localparam int ESEL_LSB = 16;
  localparam int CTL_MSB  = ESEL_LSB + 1;

  // status word positions
  localparam int LVL_BIT  = 8;
  localparam int FLG_EVT  = 0;
  localparam int FLG_RISE = 1;
  localparam int FLG_FALL = 2;
  localparam int FLG_OVR  = 3;
  localparam int FLG_MIN  = 4;

  typedef struct packed {
    role_e      role;
    logic [1:0] dir;
    logic       ien;
    logic       od;
    logic [1:0] esel;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [CTL_MSB:0] w);
    ctl_t c;
    c.role = role_e'(w[ROLE_LSB +: ROLE_W]);
    c.dir  = w[DIR_LSB +: 2];
    c.ien  = w[IEN_BIT];
    c.od   = w[OD_BIT];
    c.esel = w[ESEL_LSB +: 2];
    return c;
  endfunction

endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_n;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign stg_n[i] = d;
      end else begin : g_tail
        assign stg_n[i] = stg_q[i-1];

        AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
          stg_q[i] == $past(stg_q[i-1])); // R5
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_n;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/tpin_edge.sv
module tpin_edge
  import tpin_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl,
  input  logic              arm,
  input  logic [1:0]        esel,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_bits,
  output logic [FLAG_W-1:0] flags,
  output logic              hit
);

  logic              prev_q;
  logic              rise;
  logic              fall;
  logic [FLAG_W-1:0] set_v;
  logic [FLAG_W-1:0] clr_v;
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flags_n;
  logic              flags_en;

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    hit  = arm & ((rise & esel[0]) | (fall & esel[1]));
  end

  always_comb begin
    set_v           = '0;
    set_v[FLG_EVT]  = hit;
    set_v[FLG_RISE] = hit & rise;
    set_v[FLG_FALL] = hit & fall;
    set_v[FLG_OVR]  = hit & flags_q[FLG_EVT];
    clr_v           = clr_we ? clr_bits : '0;
    flags_n         = (flags_q & ~clr_v) | set_v;
    flags_en        = hit | clr_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      prev_q <= lvl;
      if (flags_en) begin
        flags_q <= flags_n;
      end
    end
  end

  assign flags = flags_q;

  AST_EDGE_SETS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flags_q[FLG_EVT]); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[FLG_EVT] && !hit) |=> !flags_q[FLG_EVT]); // R9

  AST_OVR_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FLG_OVR]) |-> $past(flags_q[FLG_EVT])); // R8

  AST_NO_ARM_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !flags_q[FLG_EVT]) |=> !flags_q[FLG_EVT]); // R11

endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
  import tpin_pkg::*;
(
  input  role_e      role,
  input  logic [1:0] dir,
  input  logic       od,
  input  logic       arm,
  output logic       oe,
  output logic       out
);

  logic want_drive;

  always_comb begin
    want_drive = (role == ROLE_GPIO) && !arm && dir[1];
    oe  = 1'b0;
    out = 1'b0;
    if (want_drive) begin
      if (dir[0]) begin
        oe  = !od;
        out = !od;
      end else begin
        oe  = 1'b1;
        out = 1'b0;
      end
    end
  end

endmodule

// File: rtl/tpin_ctl.sv
module tpin_ctl
  import tpin_pkg::*;
#(
  parameter int MODE_W      = 32,
  parameter int STAT_W      = 32,
  parameter int FLAG_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_bits,
  input  logic              pin_in,
  output logic              pin_oe,
  output logic              pin_out,
  output logic [MODE_W-1:0] mode_q,
  output logic [STAT_W-1:0] status_q,
  output logic              irq
);

  localparam int CTL_W = CTL_MSB + 1;

  logic [MODE_W-1:0] mode_r;
  logic [MODE_W-1:0] mode_n;
  ctl_t              ctl;
  logic              arm;
  logic              lvl;
  logic              hit;
  logic [FLAG_W-1:0] flags;

  // control word register
  always_comb begin
    mode_n = mode_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r <= '0;
    end else if (mode_we) begin
      mode_r <= mode_n;
    end
  end

  always_comb begin
    ctl = ctl_decode(mode_r[CTL_W-1:0]);
    arm = (ctl.role == ROLE_CAPT) ||
          ((ctl.role == ROLE_GPIO) && (ctl.esel != 2'b00));
  end

  tpin_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (lvl)
  );

  tpin_edge #(
    .FLAG_W (FLAG_W)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .arm      (arm),
    .esel     (ctl.esel),
    .clr_we   (clr_we),
    .clr_bits (clr_bits),
    .flags    (flags),
    .hit      (hit)
  );

  tpin_drive u_drive (
    .role (ctl.role),
    .dir  (ctl.dir),
    .od   (ctl.od),
    .arm  (arm),
    .oe   (pin_oe),
    .out  (pin_out)
  );

  always_comb begin
    status_q                 = '0;
    status_q[FLAG_W-1:0]     = flags;
    status_q[LVL_BIT]        = lvl;
    irq                      = ctl.ien & flags[FLG_EVT];
    mode_q                   = mode_r;
  end

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[OD_BIT] |-> !(pin_oe && pin_out)); // R3

  AST_ROLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[ROLE_LSB +: ROLE_W] != 3'd4) |-> !pin_oe); // R4

  AST_ARMED_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !pin_oe); // R11

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mode_q[IEN_BIT] && status_q[FLG_EVT])); // R10

  AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |-> pin_oe); // R2

  AST_HIT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q[IEN_BIT] && !mode_we) |=> irq); // R10

endmodule

// File: tb/sim_tpin_ctl.sv
module sim_tpin_ctl;

  localparam int CLK_NS = 10;

  logic        clk;
  logic        rst_n;
  logic        mode_we;
  logic [31:0] mode_wdata;
  logic        clr_we;
  logic [3:0]  clr_bits;
  logic        pin_in;
  logic        pin_oe;
  logic        pin_out;
  logic [31:0] mode_q;
  logic [31:0] status_q;
  logic        irq;

  int n_chk;
  int n_bad;
  bit done;

  tpin_ctl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .clr_we     (clr_we),
    .clr_bits   (clr_bits),
    .pin_in     (pin_in),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .mode_q     (mode_q),
    .status_q   (status_q),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // reference model state
  bit [31:0] m_mode;
  bit [3:0]  m_flags;
  bit        m_hist[$];

  function automatic bit m_arm(bit [31:0] m);
    return (m[2:0] == 3'd1) || ((m[2:0] == 3'd4) && (m[17:16] != 2'b00));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode  = '0;
      m_flags = '0;
      m_hist  = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit up, dn, got;
      bit [3:0] nf;
      up  = m_hist[1] && !m_hist[2];
      dn  = !m_hist[1] && m_hist[2];
      got = m_arm(m_mode) && ((up && m_mode[16]) || (dn && m_mode[17]));
      nf  = m_flags;
      if (clr_we) nf = nf & ~clr_bits;
      if (got) begin
        if (m_flags[0]) nf[3] = 1'b1;
        nf[0] = 1'b1;
        if (up) nf[1] = 1'b1;
        if (dn) nf[2] = 1'b1;
      end
      m_flags = nf;
      m_hist.push_front(pin_in);
      void'(m_hist.pop_back());
      if (mode_we) m_mode = mode_wdata;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done && rst_n) begin
      bit eoe, eout;
      eoe  = (m_mode[2:0] == 3'd4) && !m_arm(m_mode) && m_mode[5] &&
             !(m_mode[4] && m_mode[9]);
      eout = eoe && m_mode[4];
      chk("R1", "mode_q", int'(mode_q), int'(m_mode));
      chk("R2", "pin_oe", int'(pin_oe), int'(eoe));
      chk("R2", "pin_out", int'(pin_out), int'(eout));
      chk("R5", "level", int'(status_q[8]), int'(m_hist[1]));
      chk("R6", "flags", int'(status_q[3:0]), int'(m_flags));
      chk("R10", "irq", int'(irq), int'(m_mode[8] && m_flags[0]));
    end
  end

  task automatic wr_mode(bit [31:0] v);
    @(negedge clk);
    mode_we    = 1'b1;
    mode_wdata = v;
    @(negedge clk);
    mode_we    = 1'b0;
  endtask

  task automatic clr(bit [3:0] b);
    @(negedge clk);
    clr_we   = 1'b1;
    clr_bits = b;
    @(negedge clk);
    clr_we   = 1'b0;
  endtask

  task automatic pin_to(bit b);
    @(negedge clk);
    pin_in = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_pin(string req, bit oe, bit o);
    chk(req, "pin_oe", int'(pin_oe), int'(oe));
    chk(req, "pin_out", int'(pin_out), int'(o));
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_we = 1'b0; mode_wdata = '0;
    clr_we = 1'b0; clr_bits = '0; pin_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mode", int'(mode_q), 0);
    chk("R1", "status", int'(status_q), 0);
    expect_pin("R1", 1'b0, 1'b0);
    chk("R1", "irq", int'(irq), 0);
    rst_n = 1'b1;

    // R2 GPIO states
    wr_mode(32'h04); expect_pin("R2", 1'b0, 1'b0);
    wr_mode(32'h14); expect_pin("R2", 1'b0, 1'b0);
    wr_mode(32'h24); expect_pin("R2", 1'b1, 1'b0);
    wr_mode(32'h34); expect_pin("R2", 1'b1, 1'b1);
    // R3 open drain
    wr_mode(32'h234); expect_pin("R3", 1'b0, 1'b0);
    wr_mode(32'h224); expect_pin("R3", 1'b1, 1'b0);
    // R4 other roles
    wr_mode(32'h32); expect_pin("R4", 1'b0, 1'b0);
    wr_mode(32'h33); expect_pin("R4", 1'b0, 1'b0);
    wr_mode(32'h35); expect_pin("R4", 1'b0, 1'b0);
    wr_mode(32'h30); expect_pin("R4", 1'b0, 1'b0);
    // R5 level
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk); chk("R5", "level early", int'(status_q[8]), 0);
    @(negedge clk); chk("R5", "level", int'(status_q[8]), 1);
    pin_to(1'b0);   chk("R5", "level low", int'(status_q[8]), 0);
    chk("R11", "off role flags", int'(status_q[3:0]), 0);

    // R6 R7 R10 rising capture
    wr_mode(32'h10101);
    pin_to(1'b1);
    chk("R7", "rise flags", int'(status_q[3:0]), 4'b0011);
    chk("R10", "irq on", int'(irq), 1);
    clr(4'hF);
    chk("R9", "cleared", int'(status_q[3:0]), 0);
    chk("R10", "irq off", int'(irq), 0);
    pin_to(1'b0);
    chk("R6", "fall ignored", int'(status_q[3:0]), 0);
    wr_mode(32'h20101);
    pin_to(1'b1);
    chk("R6", "rise ignored", int'(status_q[3:0]), 0);
    pin_to(1'b0);
    chk("R7", "fall flags", int'(status_q[3:0]), 4'b0101);
    wr_mode(32'h30101);
    pin_to(1'b1);
    chk("R8", "overrun", int'(status_q[3:0]), 4'b1111);
    clr(4'b0110);
    chk("R9", "partial clear", int'(status_q[3:0]), 4'b1001);
    wr_mode(32'h30001);
    chk("R10", "masked irq", int'(irq), 0);
    clr(4'hF);
    pin_to(1'b0);
    chk("R6", "either edge", int'(status_q[3:0]), 4'b0101);
    // R9 clear in the same cycle as an edge
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk); clr_we = 1'b1; clr_bits = 4'hF;
    @(negedge clk); clr_we = 1'b0;
    chk("R9", "edge beats clear", int'(status_q[3:0]), 4'b1011);

    // R11 armed GPIO stays input and captures
    wr_mode(32'h10134);
    clr(4'hF);
    expect_pin("R11", 1'b0, 1'b0);
    pin_to(1'b0);
    pin_to(1'b1);
    chk("R11", "gpio capture", int'(status_q[3:0]), 4'b0011);
    wr_mode(32'h10002);
    clr(4'hF);
    pin_to(1'b0);
    pin_to(1'b1);
    chk("R11", "compare role no capture", int'(status_q[3:0]), 0);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      pin_in = ($urandom_range(0, 3) == 0) ? ~pin_in : pin_in;
      mode_we = ($urandom_range(0, 40) == 0);
      mode_wdata = {14'd0, 2'($urandom_range(0, 3)), 6'd0, 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 2'd0, 2'($urandom_range(0, 3)),
                    1'b0, 3'($urandom_range(0, 5))};
      clr_we = ($urandom_range(0, 15) == 0);
      clr_bits = 4'($urandom_range(0, 15));
    end
    @(negedge clk);
    mode_we = 1'b0; clr_we = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule